// File: doc/BRIEF.md
# Bank-Switching Memory Map Decoder

This block sits between an 8-bit CPU with a 16-bit address bus and its memories. It turns each memory request into exactly one chip select: the boot ROM or one of three DRAM banks. Two one-bit bank registers steer the choice. The CPU loads them with I/O writes to two fixed port numbers. Reset clears both registers, so the first instruction fetch from address 0x0000 lands in the boot ROM.

The boot ROM is visible in the lowest 4 KiB only while the bank-2 register is clear. Once that register is set, the same range reaches DRAM bank 2. The top 64 bytes of the address space always reach DRAM bank 2, whatever the registers hold. A routine that switches banks can therefore run from there and still be reachable after it changes the map. All other addresses go to DRAM bank 2 when the bank-2 register is set. Otherwise the bank-0/1 register picks DRAM bank 0 or DRAM bank 1.

Top module: `bank_mapper`

## Requirements
- R1: While reset is asserted and afterwards until the first qualifying I/O write, both bank registers read as 0. A memory access at 0x0000 selects the ROM and one at 0x5000 selects DRAM bank 0.
- R2: With `mreq_i` low, `rom_cs_o` and all bits of `dram_cs_o` are 0.
- R3: With the bank-2 register at 0, an access with address bits 15..12 all zero (0x0000 to 0x0FFF) selects the ROM.
- R4: With the bank-2 register at 1, an access in 0x0000 to 0x0FFF selects DRAM bank 2 (`dram_cs_o` = 3'b100).
- R5: An I/O write to port 0x02 (address bits 7..0) loads the bank-0/1 register from data bit 0. An I/O write to port 0x03 loads the bank-2 register from data bit 0. Data bits 7..1 are ignored.
- R6: An I/O write to any other port, including ports that differ from 0x02 or 0x03 only in bits 7..4, changes neither register.
- R7: A register loads only on a rising edge of `io_wr_i`, seen at a clock edge. If the strobe is held high for further cycles, later data changes are ignored.
- R8: An access in 0xFFC0 to 0xFFFF always selects DRAM bank 2, for all four register settings.
- R9: Outside the ROM window and the common window, the bank-2 register set selects DRAM bank 2. Otherwise the bank-0/1 register selects DRAM bank 0 (value 0, `dram_cs_o` = 3'b001) or DRAM bank 1 (value 1, `dram_cs_o` = 3'b010).
- R10: During any memory access exactly one of `rom_cs_o`, `dram_cs_o[0]`, `dram_cs_o[1]`, `dram_cs_o[2]` is high.
- R11: A memory access in the same cycle as a register-loading I/O write is decoded with the old register value. The new value applies from the cycle after the clock edge that captured the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | CPU address; bits 7..0 also carry the I/O port number |
| data_i | input | 8 | CPU write data |
| mreq_i | input | 1 | Memory request active (high) |
| io_wr_i | input | 1 | Qualified I/O write strobe (high) |
| rom_cs_o | output | 1 | Boot ROM select |
| dram_cs_o | output | 3 | DRAM bank selects; bit k selects bank k |

## Verification
A bank-register load and a memory decode can happen in the same cycle. This is how the bank-switching routine would see its own write. The bench raises the I/O write strobe for port 0x03 while `mreq_i` is high on the same address, 0x0003. That cycle must still decode as the ROM under the old value. After the capturing edge, with the strobe dropped and the access held, the same address must decode as DRAM bank 2. The reverse case is also run: the bank-2 register is cleared in that cycle, and the decode must move from bank 2 back to the ROM only after the edge.

// File: rtl/bank_map_pkg.sv
package bank_map_pkg;
  localparam int unsigned NUM_BANKS = 3;

  typedef enum logic [1:0] {
    TGT_ROM   = 2'd0,
    TGT_BANK0 = 2'd1,
    TGT_BANK1 = 2'd2,
    TGT_BANK2 = 2'd3
  } target_e;
endpackage

// File: rtl/bank_latch_regs.sv
module bank_latch_regs #(
  parameter int unsigned IO_ADDR_W = 8,
  parameter logic [IO_ADDR_W-1:0] PORT_B01 = 'h02,
  parameter logic [IO_ADDR_W-1:0] PORT_B2  = 'h03
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 io_wr_i,
  input  logic [IO_ADDR_W-1:0] io_addr_i,
  input  logic                 sel_bit_i,
  output logic                 bank01_o,
  output logic                 bank2_o
);
  logic wr_q;
  logic wr_rise;

  assign wr_rise = io_wr_i & ~wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q     <= 1'b0;
      bank01_o <= 1'b0;
      bank2_o  <= 1'b0;
    end else begin
      wr_q <= io_wr_i;
      if (wr_rise && io_addr_i == PORT_B01) bank01_o <= sel_bit_i;
      if (wr_rise && io_addr_i == PORT_B2)  bank2_o  <= sel_bit_i;
    end
  end
endmodule

// File: rtl/addr_window_decode.sv
module addr_window_decode #(
  parameter int unsigned ADDR_W       = 16,
  parameter int unsigned ROM_TOP_BITS = 4,
  parameter int unsigned COMMON_BYTES = 64
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              rom_zone_o,
  output logic              common_hit_o
);
  localparam int unsigned COMMON_LSB = $clog2(COMMON_BYTES);

  // ROM window: all top address bits zero
  assign rom_zone_o   = ~|addr_i[ADDR_W-1:ADDR_W-ROM_TOP_BITS];
  // common window: all bits above the window offset set
  assign common_hit_o = &addr_i[ADDR_W-1:COMMON_LSB];
endmodule

// File: rtl/cs_select.sv
module cs_select
  import bank_map_pkg::*;
(
  input  logic                 mreq_i,
  input  logic                 rom_zone_i,
  input  logic                 common_hit_i,
  input  logic                 bank01_i,
  input  logic                 bank2_i,
  output logic                 rom_cs_o,
  output logic [NUM_BANKS-1:0] dram_cs_o
);
  target_e tgt;

  always_comb begin
    if (common_hit_i)                 tgt = TGT_BANK2;
    else if (rom_zone_i && !bank2_i)  tgt = TGT_ROM;
    else if (bank2_i)                 tgt = TGT_BANK2;
    else if (bank01_i)                tgt = TGT_BANK1;
    else                              tgt = TGT_BANK0;
  end

  assign rom_cs_o = mreq_i && (tgt == TGT_ROM);

  for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank_cs
    localparam target_e BANK_TGT = target_e'(k + 1);
    assign dram_cs_o[k] = mreq_i && (tgt == BANK_TGT);
  end
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
  import bank_map_pkg::*;
#(
  parameter int unsigned ADDR_W       = 16,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned IO_ADDR_W    = 8,
  parameter int unsigned ROM_TOP_BITS = 4,
  parameter int unsigned COMMON_BYTES = 64,
  parameter logic [IO_ADDR_W-1:0] PORT_B01 = 'h02,
  parameter logic [IO_ADDR_W-1:0] PORT_B2  = 'h03
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    data_i,
  input  logic                 mreq_i,
  input  logic                 io_wr_i,
  output logic                 rom_cs_o,
  output logic [NUM_BANKS-1:0] dram_cs_o
);
  logic bank01_q;
  logic bank2_q;
  logic rom_zone;
  logic common_hit;
  logic unused_data;

  assign unused_data = ^data_i[DATA_W-1:1];

  bank_latch_regs #(
    .IO_ADDR_W (IO_ADDR_W),
    .PORT_B01  (PORT_B01),
    .PORT_B2   (PORT_B2)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .io_wr_i   (io_wr_i),
    .io_addr_i (addr_i[IO_ADDR_W-1:0]),
    .sel_bit_i (data_i[0]),
    .bank01_o  (bank01_q),
    .bank2_o   (bank2_q)
  );

  addr_window_decode #(
    .ADDR_W       (ADDR_W),
    .ROM_TOP_BITS (ROM_TOP_BITS),
    .COMMON_BYTES (COMMON_BYTES)
  ) u_win (
    .addr_i       (addr_i),
    .rom_zone_o   (rom_zone),
    .common_hit_o (common_hit)
  );

  cs_select u_sel (
    .mreq_i       (mreq_i),
    .rom_zone_i   (rom_zone),
    .common_hit_i (common_hit),
    .bank01_i     (bank01_q),
    .bank2_i      (bank2_q),
    .rom_cs_o     (rom_cs_o),
    .dram_cs_o    (dram_cs_o)
  );
endmodule

// File: rtl/bank_mapper_checker.sv
module bank_mapper_checker #(
  parameter int unsigned ADDR_W       = 16,
  parameter int unsigned IO_ADDR_W    = 8,
  parameter int unsigned ROM_TOP_BITS = 4,
  parameter int unsigned COMMON_BYTES = 64,
  parameter logic [IO_ADDR_W-1:0] PORT_B01 = 'h02,
  parameter logic [IO_ADDR_W-1:0] PORT_B2  = 'h03
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              mreq_i,
  input logic              io_wr_i,
  input logic              rom_cs_o,
  input logic [2:0]        dram_cs_o,
  input logic              bank01_q,
  input logic              bank2_q
);
  localparam logic [ADDR_W:0] COMMON_BASE = (1 << ADDR_W) - COMMON_BYTES;

  logic in_rom_win;
  logic in_common;
  assign in_rom_win = (addr_i >> (ADDR_W - ROM_TOP_BITS)) == 0;
  assign in_common  = {1'b0, addr_i} >= COMMON_BASE;

  assert_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mreq_i |-> ({rom_cs_o, dram_cs_o} == 4'b0000));

  assert_rom_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mreq_i && in_rom_win && !bank2_q) |-> rom_cs_o);

  assert_low_bank2_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mreq_i && in_rom_win && bank2_q) |-> dram_cs_o[2]);

  assert_b01_src_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(bank01_q) |-> $past(io_wr_i && addr_i[IO_ADDR_W-1:0] == PORT_B01));

  assert_b2_src_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(bank2_q) |-> $past(io_wr_i && addr_i[IO_ADDR_W-1:0] == PORT_B2));

  assert_common_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mreq_i && in_common) |-> (dram_cs_o == 3'b100 && !rom_cs_o));

  assert_one_cs_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mreq_i |-> ($countones({rom_cs_o, dram_cs_o}) == 1));
endmodule

bind bank_mapper bank_mapper_checker #(
  .ADDR_W       (ADDR_W),
  .IO_ADDR_W    (IO_ADDR_W),
  .ROM_TOP_BITS (ROM_TOP_BITS),
  .COMMON_BYTES (COMMON_BYTES),
  .PORT_B01     (PORT_B01),
  .PORT_B2      (PORT_B2)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .mreq_i    (mreq_i),
  .io_wr_i   (io_wr_i),
  .rom_cs_o  (rom_cs_o),
  .dram_cs_o (dram_cs_o),
  .bank01_q  (bank01_q),
  .bank2_q   (bank2_q)
);

// File: tb/bank_mapper_bench.sv
`timescale 1ns/1ps
module bank_mapper_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr_i = '0;
  logic [7:0]  data_i = '0;
  logic        mreq_i = 1'b0;
  logic        io_wr_i = 1'b0;
  logic        rom_cs_o;
  logic [2:0]  dram_cs_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit m_b01 = 1'b0;
  bit m_b2  = 1'b0;

  always #10 clk_i = ~clk_i;

  bank_mapper u_bank_mapper (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_i),
    .data_i    (data_i),
    .mreq_i    (mreq_i),
    .io_wr_i   (io_wr_i),
    .rom_cs_o  (rom_cs_o),
    .dram_cs_o (dram_cs_o)
  );

  // {bank2, bank1, bank0, rom}
  function automatic logic [3:0] exp_cs(logic [15:0] a, logic mr, bit b01, bit b2);
    if (!mr)                 return 4'b0000;
    if (a >= 16'hFFC0)       return 4'b1000;
    if (a[15:12] == 0 && !b2) return 4'b0001;
    if (b2)                  return 4'b1000;
    return b01 ? 4'b0100 : 4'b0010;
  endfunction

  task automatic check(string req, logic [3:0] expv);
    logic [3:0] act;
    act = {dram_cs_o, rom_cs_o};
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s addr=%h mreq=%0b actual=%b expected=%b", req, addr_i, mreq_i, act, expv);
    end
  endtask

  task automatic probe(string req, logic [15:0] a, logic mr);
    addr_i = a;
    mreq_i = mr;
    #1;
    check(req, exp_cs(a, mr, m_b01, m_b2));
  endtask

  task automatic io_write(logic [7:0] port, logic [7:0] d);
    @(negedge clk_i);
    mreq_i  = 1'b0;
    addr_i  = {8'h00, port};
    data_i  = d;
    io_wr_i = 1'b1;
    @(negedge clk_i);
    io_wr_i = 1'b0;
    #1;
  endtask

  // covers R3 R8 R9 R10 R2 for the current model state
  task automatic sweep(string req);
    for (int a = 0; a < 65536; a += 64) begin
      probe(req, 16'(a), 1'b1);
      probe(req, 16'(a + 63), 1'b1);
      probe("R2", 16'(a), 1'b0);
    end
    mreq_i = 1'b0;
  endtask

  initial begin
    // R1: reset state
    #3;
    probe("R1", 16'h0000, 1'b1);
    probe("R1", 16'h5000, 1'b1);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    probe("R1", 16'h0000, 1'b1);

    sweep("R3_R8_R9_R10");

    // R5: only bit 0 counts
    io_write(8'h02, 8'hFE);
    probe("R5", 16'h5000, 1'b1);
    io_write(8'h02, 8'h01);
    m_b01 = 1'b1;
    probe("R5", 16'h5000, 1'b1);

    // R6: alias ports must not load
    io_write(8'h12, 8'h00);
    probe("R6", 16'h5000, 1'b1);
    io_write(8'h82, 8'h00);
    probe("R6", 16'h5000, 1'b1);
    io_write(8'h83, 8'h01);
    probe("R6", 16'h0000, 1'b1);
    io_write(8'h04, 8'h01);
    probe("R6", 16'h0000, 1'b1);
    probe("R6", 16'h7000, 1'b1);

    sweep("R3_R8_R9_R10");

    // R7: strobe held high, data changes afterwards ignored
    @(negedge clk_i);
    mreq_i = 1'b0; addr_i = 16'h0003; data_i = 8'h01; io_wr_i = 1'b1;
    @(negedge clk_i); data_i = 8'h00;
    @(negedge clk_i); data_i = 8'h00;
    @(negedge clk_i); io_wr_i = 1'b0;
    m_b2 = 1'b1;
    probe("R7", 16'h0000, 1'b1);
    probe("R4", 16'h0FFF, 1'b1);

    sweep("R4_R8_R9_R10");

    // R11: write and access in the same cycle (clear bank2)
    @(negedge clk_i);
    addr_i = 16'h0003; data_i = 8'h00; mreq_i = 1'b1; io_wr_i = 1'b1;
    #1 check("R11", 4'b1000);
    @(negedge clk_i);
    io_wr_i = 1'b0;
    #1 check("R11", 4'b0001);
    m_b2 = 1'b0;
    // R11: set bank2 in the same cycle as an access
    @(negedge clk_i);
    data_i = 8'h01; io_wr_i = 1'b1;
    #1 check("R11", 4'b0001);
    @(negedge clk_i);
    io_wr_i = 1'b0;
    #1 check("R11", 4'b1000);
    m_b2 = 1'b1;

    io_write(8'h02, 8'h00);
    m_b01 = 1'b0;
    sweep("R4_R8_R9_R10");

    io_write(8'h03, 8'h00);
    m_b2 = 1'b0;
    sweep("R3_R8_R9_R10");

    // R1: reset mid-run clears both registers
    io_write(8'h02, 8'h01);
    io_write(8'h03, 8'h01);
    m_b01 = 1'b1; m_b2 = 1'b1;
    probe("R9", 16'h5000, 1'b1);
    @(negedge clk_i);
    rst_ni = 1'b0;
    m_b01 = 1'b0; m_b2 = 1'b0;
    probe("R1", 16'h0000, 1'b1);
    probe("R1", 16'h5000, 1'b1);
    @(negedge clk_i);
    rst_ni = 1'b1;
    probe("R1", 16'h5000, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule